// File: doc/BRIEF.md
# Two-Player Turn Sequencer

This block runs the turn order of a two-player artillery game. It takes decoded controller events: four direction presses, an aim toggle and a fire command. It routes them to the tank unit of whichever player holds the turn. Each turn has two parts. First comes a pre-launch part, in which the player can move the tank or switch into an aim sub-mode that steps a 3-bit shot force. Then comes a single launch. After the launch the sequencer waits for the shooting tank's shot-complete response and then gives the turn to the other player.

The sequencer also counts the hit notifications that each tank reports. Every tank starts with six units of health. As soon as either tank's health reaches zero, the game ends, a winner code is latched, and every further input is ignored until reset. A start input leaves the idle state after reset, and the first turn always belongs to player 1.

Top module: `turn_sequencer`

## Requirements
- R1: After reset neither tank enable is high, `game_over` is 0, `winner` is 2'b00, `aim_mode` is 0, `shot_force` equals FORCE_INIT (3), and both health outputs equal HITS_TO_KILL (6).
- R2: In idle, a `start` pulse gives the turn to player 1 at the next clock edge (`active_player` 0, `t1_en` 1). Before that, direction, fire and hit inputs have no effect.
- R3: While a game is running, exactly one of `t1_en`/`t2_en` is high, selected by `active_player` (0 = player 1, 1 = player 2). In idle and after game over, both are low.
- R4: In the move phase, direction events appear in the same cycle on the active tank's move bus as bit 3 = up, bit 2 = down, bit 1 = left, bit 0 = right. The passive tank's move bus stays zero.
- R5: `ev_aim` toggles between the move phase and the aim sub-mode (`aim_mode` 1). In aim, `ev_up` raises and `ev_down` lowers `shot_force` by one per cycle, saturating at 0 and at 7. Both move buses stay zero in aim.
- R6: `ev_fire` in the move phase or in aim pulses the active tank's launch output in the same cycle, with `shot_force` valid, and starts the flight phase. Fire takes priority over aim toggling and force stepping. During flight, direction, aim and fire inputs produce no move, no launch and no force change.
- R7: During flight, the active tank's done input hands the turn to the other player at the next edge, in the move phase. The passive tank's done input is ignored.
- R8: A hit input lowers that tank's health by one at the next edge while a game is running. Hits are ignored in idle and after game over.
- R9: When a hit takes a tank's health to zero, the next edge sets `game_over` and sets `winner` to the other player (2'b01 = player 1, 2'b10 = player 2). The turn is not handed over, even if a done arrives in the same cycle. If both tanks reach zero in the same cycle, the active player wins.
- R10: After game over, all inputs except reset are ignored. `winner`, health and force hold stable, and no move or launch is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a game from idle |
| ev_up | input | 1 | Up event (move, or force up in aim) |
| ev_down | input | 1 | Down event (move, or force down in aim) |
| ev_left | input | 1 | Left event |
| ev_right | input | 1 | Right event |
| ev_aim | input | 1 | Toggle between move phase and aim sub-mode |
| ev_fire | input | 1 | Launch the shot |
| t1_done | input | 1 | Player 1 tank: shot complete |
| t2_done | input | 1 | Player 2 tank: shot complete |
| t1_hit | input | 1 | Player 1 tank was hit |
| t2_hit | input | 1 | Player 2 tank was hit |
| t1_en | output | 1 | Player 1 tank enabled |
| t2_en | output | 1 | Player 2 tank enabled |
| t1_move | output | 4 | Player 1 move pulses {up,down,left,right} |
| t2_move | output | 4 | Player 2 move pulses {up,down,left,right} |
| t1_launch | output | 1 | Player 1 launch pulse |
| t2_launch | output | 1 | Player 2 launch pulse |
| shot_force | output | FORCE_W | Current shot force |
| aim_mode | output | 1 | Aim sub-mode active |
| active_player | output | 1 | 0 = player 1 turn, 1 = player 2 turn |
| game_over | output | 1 | A winner has been decided |
| winner | output | 2 | 00 none, 01 player 1, 10 player 2 |
| t1_health | output | HW | Player 1 remaining health |
| t2_health | output | HW | Player 2 remaining health |

## Verification
The lethal hit and the shooter's done response can arrive in the same cycle. Turn handover and game-over then compete for the next state. The bench drives the sixth hit on player 2 together with `t1_done` and requires game over with player 1 as winner and no enable on player 2. It also drives fatal hits on both tanks in one cycle and requires the active player to be named winner.

// File: rtl/turn_sequencer.sv
module turn_sequencer #(
  parameter int HITS_TO_KILL = 6,
  parameter int FORCE_W      = 3,
  parameter int FORCE_INIT   = 3,
  localparam int HW          = $clog2(HITS_TO_KILL + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               ev_up,
  input  logic               ev_down,
  input  logic               ev_left,
  input  logic               ev_right,
  input  logic               ev_aim,
  input  logic               ev_fire,
  input  logic               t1_done,
  input  logic               t2_done,
  input  logic               t1_hit,
  input  logic               t2_hit,
  output logic               t1_en,
  output logic               t2_en,
  output logic [3:0]         t1_move,
  output logic [3:0]         t2_move,
  output logic               t1_launch,
  output logic               t2_launch,
  output logic [FORCE_W-1:0] shot_force,
  output logic               aim_mode,
  output logic               active_player,
  output logic               game_over,
  output logic [1:0]         winner,
  output logic [HW-1:0]      t1_health,
  output logic [HW-1:0]      t2_health
);
  localparam logic [FORCE_W-1:0] FMAX  = '1;
  localparam logic [HW-1:0]      HFULL = HW'(HITS_TO_KILL);

  typedef enum logic [2:0] {S_IDLE, S_MOVE, S_AIM, S_FLIGHT, S_OVER} st_t;

  st_t               st;
  logic              turn;
  logic [FORCE_W-1:0] frc;
  logic [HW-1:0]     h1, h2;
  logic [1:0]        win;

  wire live = (st == S_MOVE) || (st == S_AIM) || (st == S_FLIGHT);
  wire pre  = (st == S_MOVE) || (st == S_AIM);
  wire [3:0] dirs = {ev_up, ev_down, ev_left, ev_right};
  wire fire = pre & ev_fire;
  wire done = (st == S_FLIGHT) && (turn ? t2_done : t1_done);

  wire [HW-1:0] h1_nx = (live && t1_hit && h1 != '0) ? h1 - 1'b1 : h1;
  wire [HW-1:0] h2_nx = (live && t2_hit && h2 != '0) ? h2 - 1'b1 : h2;
  wire dead1 = live && (h1_nx == '0);
  wire dead2 = live && (h2_nx == '0);

  assign t1_en         = live & ~turn;
  assign t2_en         = live &  turn;
  assign t1_move       = (st == S_MOVE && !turn) ? dirs : 4'b0000;
  assign t2_move       = (st == S_MOVE &&  turn) ? dirs : 4'b0000;
  assign t1_launch     = fire & ~turn;
  assign t2_launch     = fire &  turn;
  assign shot_force    = frc;
  assign aim_mode      = (st == S_AIM);
  assign active_player = turn;
  assign game_over     = (st == S_OVER);
  assign winner        = win;
  assign t1_health     = h1;
  assign t2_health     = h2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      turn <= 1'b0;
      frc  <= FORCE_W'(FORCE_INIT);
      h1   <= HFULL;
      h2   <= HFULL;
      win  <= 2'b00;
    end else if (st == S_IDLE) begin
      if (start) begin
        st   <= S_MOVE;
        turn <= 1'b0;
      end
    end else if (live) begin
      h1 <= h1_nx;
      h2 <= h2_nx;
      if (dead1 || dead2) begin
        st <= S_OVER;
        if (dead1 && dead2) win <= turn ? 2'b10 : 2'b01;
        else if (dead1)     win <= 2'b10;
        else                win <= 2'b01;
      end else if (fire) begin
        st <= S_FLIGHT;
      end else if (st == S_MOVE) begin
        if (ev_aim) st <= S_AIM;
      end else if (st == S_AIM) begin
        if (ev_aim) st <= S_MOVE;
        else if (ev_up && !ev_down && frc != FMAX) frc <= frc + 1'b1;
        else if (ev_down && !ev_up && frc != '0)  frc <= frc - 1'b1;
      end else if (done) begin
        st   <= S_MOVE;
        turn <= ~turn;
      end
    end
  end
endmodule

// File: rtl/turn_sequencer_chk.sv
module turn_sequencer_chk #(
  parameter int FW = 3,
  parameter int HW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          t1_en,
  input logic          t2_en,
  input logic [3:0]    t1_move,
  input logic [3:0]    t2_move,
  input logic          t1_launch,
  input logic          t2_launch,
  input logic [FW-1:0] shot_force,
  input logic          game_over,
  input logic [1:0]    winner,
  input logic [HW-1:0] t1_health,
  input logic [HW-1:0] t2_health
);
  AST_SINGLE_TURN: assert property (@(posedge clk) disable iff (!rst_n) !(t1_en && t2_en)); // R3
  AST_PASSIVE1_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !t1_en |-> (t1_move == 4'b0 && !t1_launch)); // R4
  AST_PASSIVE2_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !t2_en |-> (t2_move == 4'b0 && !t2_launch)); // R4
  AST_FORCE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (shot_force != $past(shot_force)) |->
      (FW'(shot_force - $past(shot_force)) == FW'(1) || FW'($past(shot_force) - shot_force) == FW'(1))); // R5
  AST_LAUNCH_ENDS: assert property (@(posedge clk) disable iff (!rst_n) (t1_launch || t2_launch) |=> !(t1_launch || t2_launch)); // R6
  AST_HEALTH_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_health <= $past(t1_health)) && (t2_health <= $past(t2_health))); // R8
  AST_OVER_QUIET: assert property (@(posedge clk) disable iff (!rst_n) game_over |-> (!t1_en && !t2_en && winner != 2'b00)); // R9
  AST_WINNER_HOLD: assert property (@(posedge clk) disable iff (!rst_n) game_over |=> (game_over && $stable(winner))); // R10
endmodule

bind turn_sequencer turn_sequencer_chk #(.FW(FORCE_W), .HW(HW)) u_chk (
  .clk(clk), .rst_n(rst_n), .t1_en(t1_en), .t2_en(t2_en),
  .t1_move(t1_move), .t2_move(t2_move), .t1_launch(t1_launch), .t2_launch(t2_launch),
  .shot_force(shot_force), .game_over(game_over), .winner(winner),
  .t1_health(t1_health), .t2_health(t2_health)
);

// File: tb/turn_sequencer_bench.sv
module turn_sequencer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start, ev_up, ev_down, ev_left, ev_right, ev_aim, ev_fire;
  logic t1_done, t2_done, t1_hit, t2_hit;
  logic t1_en, t2_en, t1_launch, t2_launch, aim_mode, active_player, game_over;
  logic [3:0] t1_move, t2_move;
  logic [2:0] shot_force, t1_health, t2_health;
  logic [1:0] winner;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  turn_sequencer u_turn_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .ev_up(ev_up), .ev_down(ev_down),
    .ev_left(ev_left), .ev_right(ev_right), .ev_aim(ev_aim), .ev_fire(ev_fire),
    .t1_done(t1_done), .t2_done(t2_done), .t1_hit(t1_hit), .t2_hit(t2_hit),
    .t1_en(t1_en), .t2_en(t2_en), .t1_move(t1_move), .t2_move(t2_move),
    .t1_launch(t1_launch), .t2_launch(t2_launch), .shot_force(shot_force),
    .aim_mode(aim_mode), .active_player(active_player), .game_over(game_over),
    .winner(winner), .t1_health(t1_health), .t2_health(t2_health));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr();
    {start, ev_up, ev_down, ev_left, ev_right, ev_aim, ev_fire} = '0;
    {t1_done, t2_done, t1_hit, t2_hit} = '0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic do_reset();
    clr();
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    settle();
    chk("R1 t1_en", 32'(t1_en), 0);
    chk("R1 t2_en", 32'(t2_en), 0);
    chk("R1 game_over", 32'(game_over), 0);
    chk("R1 winner", 32'(winner), 0);
    chk("R1 aim_mode", 32'(aim_mode), 0);
    chk("R1 force", 32'(shot_force), 3);
    chk("R1 health1", 32'(t1_health), 6);
    chk("R1 health2", 32'(t2_health), 6);
    ev_up = 1; ev_fire = 1; t1_hit = 1;
    settle();
    chk("R2 idle no move", 32'(t1_move), 0);
    chk("R2 idle no launch", 32'(t1_launch), 0);
    step();
    clr();
    chk("R2 idle hit ignored", 32'(t1_health), 6);
    chk("R2 still idle", 32'(t1_en), 0);
  endtask

  task automatic t_start();
    start = 1;
    step();
    clr();
    chk("R2 p1 enabled", 32'(t1_en), 1);
    chk("R3 p2 off", 32'(t2_en), 0);
    chk("R2 active p1", 32'(active_player), 0);
  endtask

  task automatic t_move();
    ev_up = 1; ev_left = 1;
    settle();
    chk("R4 p1 move up+left", 32'(t1_move), 4'b1010);
    chk("R4 p2 quiet", 32'(t2_move), 0);
    step();
    clr();
    ev_down = 1; ev_right = 1;
    settle();
    chk("R4 p1 move down+right", 32'(t1_move), 4'b0101);
    step();
    clr();
  endtask

  task automatic t_aim();
    ev_aim = 1;
    step();
    clr();
    chk("R5 aim on", 32'(aim_mode), 1);
    for (int i = 0; i < 6; i++) begin
      ev_up = 1;
      step();
    end
    clr();
    chk("R5 force sat max", 32'(shot_force), 7);
    ev_left = 1; ev_up = 1;
    settle();
    chk("R5 no move in aim", 32'(t1_move), 0);
    clr();
    for (int i = 0; i < 9; i++) begin
      ev_down = 1;
      step();
    end
    clr();
    chk("R5 force sat min", 32'(shot_force), 0);
    ev_up = 1; ev_down = 1;
    step();
    clr();
    chk("R5 up+down no step", 32'(shot_force), 0);
    for (int i = 0; i < 5; i++) begin
      ev_up = 1;
      step();
    end
    clr();
    chk("R5 force 5", 32'(shot_force), 5);
    ev_aim = 1;
    step();
    clr();
    chk("R5 aim off", 32'(aim_mode), 0);
  endtask

  task automatic t_fire();
    ev_aim = 1;
    step();
    clr();
    ev_fire = 1; ev_up = 1;
    settle();
    chk("R6 launch p1", 32'(t1_launch), 1);
    chk("R6 no launch p2", 32'(t2_launch), 0);
    chk("R6 force at launch", 32'(shot_force), 5);
    step();
    clr();
    chk("R6 fire beats step", 32'(shot_force), 5);
    chk("R6 left aim", 32'(aim_mode), 0);
    ev_fire = 1; ev_up = 1; ev_right = 1;
    settle();
    chk("R6 flight no launch", 32'(t1_launch), 0);
    chk("R6 flight no move", 32'(t1_move), 0);
    step();
    clr();
    ev_aim = 1; ev_down = 1;
    step();
    clr();
    chk("R6 flight aim ignored", 32'(aim_mode), 0);
    chk("R6 flight force held", 32'(shot_force), 5);
  endtask

  task automatic t_handover();
    t2_done = 1;
    step();
    clr();
    chk("R7 passive done ignored", 32'(t1_en), 1);
    t1_hit = 1;
    step();
    clr();
    chk("R8 p1 hit", 32'(t1_health), 5);
    t1_done = 1;
    step();
    clr();
    chk("R7 p2 turn", 32'(t2_en), 1);
    chk("R7 active p2", 32'(active_player), 1);
    chk("R3 p1 off", 32'(t1_en), 0);
    ev_up = 1;
    settle();
    chk("R4 p2 move", 32'(t2_move), 4'b1000);
    chk("R4 p1 quiet", 32'(t1_move), 0);
    clr();
    ev_fire = 1;
    settle();
    chk("R6 p2 launch", 32'(t2_launch), 1);
    step();
    clr();
    t2_done = 1;
    step();
    clr();
    chk("R7 back to p1", 32'(t1_en), 1);
  endtask

  task automatic t_kill();
    ev_fire = 1;
    step();
    clr();
    for (int i = 0; i < 5; i++) begin
      t2_hit = 1;
      step();
    end
    clr();
    chk("R8 p2 health 1", 32'(t2_health), 1);
    chk("R9 not over yet", 32'(game_over), 0);
    t2_hit = 1; t1_done = 1;
    step();
    clr();
    chk("R9 game over", 32'(game_over), 1);
    chk("R9 winner p1", 32'(winner), 2'b01);
    chk("R9 no handover", 32'(t2_en), 0);
    chk("R9 p2 health 0", 32'(t2_health), 0);
  endtask

  task automatic t_over();
    start = 1; ev_fire = 1; ev_up = 1; ev_aim = 1; t1_hit = 1; t2_hit = 1; t1_done = 1; t2_done = 1;
    settle();
    chk("R10 no launch", 32'({t1_launch, t2_launch}), 0);
    chk("R10 no move", 32'({t1_move, t2_move}), 0);
    step();
    step();
    clr();
    chk("R10 winner held", 32'(winner), 2'b01);
    chk("R10 still over", 32'(game_over), 1);
    chk("R10 health1 held", 32'(t1_health), 5);
    chk("R10 force held", 32'(shot_force), 5);
  endtask

  task automatic t_tie();
    do_reset();
    start = 1;
    step();
    clr();
    ev_fire = 1;
    step();
    clr();
    t1_done = 1;
    step();
    clr();
    chk("R7 p2 turn for tie", 32'(active_player), 1);
    for (int i = 0; i < 5; i++) begin
      t1_hit = 1; t2_hit = 1;
      step();
    end
    clr();
    chk("R8 both health 1", 32'({t1_health, t2_health}), {3'd1, 3'd1});
    t1_hit = 1; t2_hit = 1;
    step();
    clr();
    chk("R9 tie over", 32'(game_over), 1);
    chk("R9 tie active wins", 32'(winner), 2'b10);
  endtask

  initial begin
    #(4 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clr();
    t_reset();
    t_start();
    t_move();
    t_aim();
    t_fire();
    t_handover();
    t_kill();
    t_over();
    t_tie();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule